// File: doc/BRIEF.md
# CAN bit-segment solver

This block turns three system constraints into a complete set of CAN bit-segment settings. The constraints are the round-trip signal delay on the bus in nanoseconds, the length of one time quantum in nanoseconds, and the nominal bit time counted in quanta. The synchronisation segment is fixed at one quantum. The propagation segment is the round-trip delay divided by the quantum and rounded up. The quanta left over are split between the two phase segments. The resynchronisation jump width is the first phase segment, limited to four.

Two oscillator-tolerance bounds follow from these settings. One comes from the jump width and one comes from the phase segments. The block reports both bounds and their minimum as unsigned Q0.16 fractions. A single shared restoring divider computes every division, one after another.

Software or a boot sequencer places the constraints on the inputs and pulses `start_i`, then waits for the one-cycle `done_o`. The results stay on the outputs until the next accepted start. `err_o` rises together with `done_o` when the constraints cannot be met.

Top module: `can_seg_solver`

## Requirements
- R1: The propagation segment equals (rtt + tq - 1) / tq in integer arithmetic, that is, the round-trip delay divided by the quantum length and rounded up; an exact multiple is not rounded further.
- R2: When the remainder (nbt - 1 - prop) is even, both phase segments equal half of it.
- R3: When the remainder is odd, phase segment 1 is floor(remainder/2) and phase segment 2 is one more than phase segment 1.
- R4: The jump width equals the smaller of 4 and phase segment 1.
- R5: `tol_rjw_o` equals floor(rjw * 65536 / (20 * nbt)).
- R6: `tol_phase_o` equals floor(min(ph1, ph2) * 65536 / (2 * (13 * nbt - ph2))).
- R7: `tol_o` equals the smaller of `tol_rjw_o` and `tol_phase_o`.
- R8: If nbt is outside 8..25, or tq is 0, `err_o` is 1 at done and every segment and tolerance output is 0.
- R9: If the rounded-up propagation segment exceeds 8, `err_o` is 1 at done and all result outputs are 0.
- R10: If the remainder is less than 2, `err_o` is 1 at done and all result outputs are 0; a remainder of exactly 2 is accepted.
- R11: `done_o` is high for exactly one cycle per accepted start. All outputs then hold their values until the next start, even if the data inputs change.
- R12: A start pulse that arrives while a computation is in progress is ignored. It does not change the results and does not produce an extra done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a computation (accepted when idle) |
| rtt_ns_i | input | 16 | Round-trip propagation delay in ns |
| tq_ns_i | input | 16 | Time-quantum length in ns |
| nbt_i | input | 5 | Nominal bit time in quanta |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Constraints infeasible |
| prop_seg_o | output | 4 | Propagation segment in quanta |
| phase1_o | output | 5 | Phase segment 1 in quanta |
| phase2_o | output | 5 | Phase segment 2 in quanta |
| rjw_o | output | 3 | Resynchronisation jump width |
| tol_rjw_o | output | 16 | Tolerance bound from jump width, Q0.16 |
| tol_phase_o | output | 16 | Tolerance bound from phase segments, Q0.16 |
| tol_o | output | 16 | Reported tolerance, Q0.16 |

## Verification
The solver is run on several constraint sets, each chosen to exercise a different path:
- an even remainder with a rounded-up propagation segment;
- a delay that is an exact multiple of the quantum, which separates round-up from truncation plus one;
- an odd remainder, which shows which phase segment takes the extra quantum;
- a long bit time, where the jump-width cap applies and the jump-width bound becomes the smaller tolerance;
- a case where the two bounds swap roles.

Boundary sets try the following:
- nbt just inside and just outside 8..25;
- a zero quantum;
- a propagation segment of exactly 8 and of 9;
- remainders of 2 and 1.

These show each error condition apart from the accepted edge beside it. A start issued mid-computation and input changes after done show whether results are tied to the accepted start only.

// File: rtl/can_seg_pkg.sv
package can_seg_pkg;
  parameter int unsigned NS_W     = 16;
  parameter int unsigned NBT_W    = 5;
  parameter int unsigned FRAC_W   = 16;
  parameter int unsigned PROP_W   = 4;
  parameter int unsigned PH_W     = 5;
  parameter int unsigned RJW_W    = 3;
  parameter int unsigned NBT_MIN  = 8;
  parameter int unsigned NBT_MAX  = 25;
  parameter int unsigned PROP_MAX = 8;
  parameter int unsigned RJW_MAX  = 4;
  localparam int unsigned QUO_W   = NS_W + FRAC_W;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_PROP, S_TOL1, S_TOL2
  } state_e;
endpackage

// File: rtl/can_div_seq.sv
// Restoring divider, one quotient bit per cycle.
module can_div_seq #(
  parameter int unsigned NUM_W = 32,
  parameter int unsigned DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem_q, shl;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign shl = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (go_i) begin
      rem_q  <= '0;
      quo_q  <= num_i;
      cnt_q  <= CNT_W'(NUM_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (shl >= {1'b0, den_i}) begin
        rem_q <= shl - {1'b0, den_i};
        quo_q <= {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_q <= shl;
        quo_q <= {quo_q[NUM_W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/can_seg_alloc.sv
// Segment split from the rounded-up propagation quotient.
module can_seg_alloc
  import can_seg_pkg::*;
(
  input  logic [QUO_W-1:0]  quo_i,
  input  logic [NBT_W-1:0]  nbt_i,
  output logic [PROP_W-1:0] prop_o,
  output logic [PH_W-1:0]   ph1_o,
  output logic [PH_W-1:0]   ph2_o,
  output logic [RJW_W-1:0]  rjw_o,
  output logic              err_o
);
  logic [NBT_W:0]   need;
  logic [NBT_W-1:0] rem;

  always_comb begin
    prop_o = quo_i[PROP_W-1:0];
    need   = (NBT_W+1)'(prop_o) + (NBT_W+1)'(3);
    err_o  = (quo_i > QUO_W'(PROP_MAX)) || (need > (NBT_W+1)'(nbt_i));
    rem    = nbt_i - NBT_W'(prop_o) - NBT_W'(1);
    ph1_o  = PH_W'(rem >> 1);
    ph2_o  = PH_W'(rem) - ph1_o;
    rjw_o  = (ph1_o < PH_W'(RJW_MAX)) ? RJW_W'(ph1_o) : RJW_W'(RJW_MAX);
  end
endmodule

// File: rtl/can_seg_solver.sv
module can_seg_solver
  import can_seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NS_W-1:0]   rtt_ns_i,
  input  logic [NS_W-1:0]   tq_ns_i,
  input  logic [NBT_W-1:0]  nbt_i,
  output logic              done_o,
  output logic              err_o,
  output logic [PROP_W-1:0] prop_seg_o,
  output logic [PH_W-1:0]   phase1_o,
  output logic [PH_W-1:0]   phase2_o,
  output logic [RJW_W-1:0]  rjw_o,
  output logic [FRAC_W-1:0] tol_rjw_o,
  output logic [FRAC_W-1:0] tol_phase_o,
  output logic [FRAC_W-1:0] tol_o
);
  state_e            state_q;
  logic [NS_W-1:0]   rtt_q, tq_q, den_q;
  logic [NBT_W-1:0]  nbt_q;
  logic [QUO_W-1:0]  num_q, div_quo;
  logic              go_q, div_done;

  logic [PROP_W-1:0] sa_prop;
  logic [PH_W-1:0]   sa_ph1, sa_ph2, ph_min;
  logic [RJW_W-1:0]  sa_rjw;
  logic              sa_err, bad_in;
  logic [NS_W-1:0]   den_t1, den_t2;
  logic [FRAC_W-1:0] q_frac;

  can_div_seq #(.NUM_W(QUO_W), .DEN_W(NS_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_q),
    .num_i  (num_q),
    .den_i  (den_q),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  can_seg_alloc i_alloc (
    .quo_i  (div_quo),
    .nbt_i  (nbt_q),
    .prop_o (sa_prop),
    .ph1_o  (sa_ph1),
    .ph2_o  (sa_ph2),
    .rjw_o  (sa_rjw),
    .err_o  (sa_err)
  );

  assign bad_in = (nbt_q < NBT_W'(NBT_MIN)) || (nbt_q > NBT_W'(NBT_MAX)) || (tq_q == '0);
  assign den_t1 = NS_W'(20) * NS_W'(nbt_q);
  assign den_t2 = NS_W'(2) * (NS_W'(13) * NS_W'(nbt_q) - NS_W'(phase2_o));
  assign ph_min = (phase1_o < phase2_o) ? phase1_o : phase2_o;
  assign q_frac = div_quo[FRAC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      rtt_q       <= '0;
      tq_q        <= '0;
      nbt_q       <= '0;
      num_q       <= '0;
      den_q       <= '0;
      go_q        <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      prop_seg_o  <= '0;
      phase1_o    <= '0;
      phase2_o    <= '0;
      rjw_o       <= '0;
      tol_rjw_o   <= '0;
      tol_phase_o <= '0;
      tol_o       <= '0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          rtt_q       <= rtt_ns_i;
          tq_q        <= tq_ns_i;
          nbt_q       <= nbt_i;
          err_o       <= 1'b0;
          prop_seg_o  <= '0;
          phase1_o    <= '0;
          phase2_o    <= '0;
          rjw_o       <= '0;
          tol_rjw_o   <= '0;
          tol_phase_o <= '0;
          tol_o       <= '0;
          state_q     <= S_CHK;
        end
        S_CHK: if (bad_in) begin
          err_o   <= 1'b1;
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end else begin
          num_q   <= QUO_W'(rtt_q) + QUO_W'(tq_q) - QUO_W'(1);
          den_q   <= tq_q;
          go_q    <= 1'b1;
          state_q <= S_PROP;
        end
        S_PROP: if (div_done) begin
          if (sa_err) begin
            err_o   <= 1'b1;
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            prop_seg_o <= sa_prop;
            phase1_o   <= sa_ph1;
            phase2_o   <= sa_ph2;
            rjw_o      <= sa_rjw;
            num_q      <= QUO_W'(sa_rjw) << FRAC_W;
            den_q      <= den_t1;
            go_q       <= 1'b1;
            state_q    <= S_TOL1;
          end
        end
        S_TOL1: if (div_done) begin
          tol_rjw_o <= q_frac;
          num_q     <= QUO_W'(ph_min) << FRAC_W;
          den_q     <= den_t2;
          go_q      <= 1'b1;
          state_q   <= S_TOL2;
        end
        S_TOL2: if (div_done) begin
          tol_phase_o <= q_frac;
          tol_o       <= (q_frac < tol_rjw_o) ? q_frac : tol_rjw_o;
          done_o      <= 1'b1;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/can_seg_solver_chk.sv
module can_seg_solver_chk
  import can_seg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic              err_o,
  input logic [PROP_W-1:0] prop_seg_o,
  input logic [PH_W-1:0]   phase1_o,
  input logic [PH_W-1:0]   phase2_o,
  input logic [RJW_W-1:0]  rjw_o,
  input logic [FRAC_W-1:0] tol_rjw_o,
  input logic [FRAC_W-1:0] tol_phase_o,
  input logic [FRAC_W-1:0] tol_o
);
  logic held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= 1'b0;
    else if (done_o)  held_q <= 1'b1;
    else if (start_i) held_q <= 1'b0;
  end

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !start_i) |=> ($stable(tol_o) && $stable(prop_seg_o) &&
                              $stable(phase1_o) && $stable(phase2_o) && $stable(err_o)));

  p_rjw_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (rjw_o <= RJW_W'(RJW_MAX) && PH_W'(rjw_o) <= phase1_o));

  p_split_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (phase2_o == phase1_o || phase2_o == phase1_o + 1'b1));

  p_prop_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (prop_seg_o <= PROP_W'(PROP_MAX)));

  p_rem_min_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (phase1_o >= PH_W'(1)));

  p_tol_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (tol_o <= tol_rjw_o && tol_o <= tol_phase_o &&
                            (tol_o == tol_rjw_o || tol_o == tol_phase_o)));

  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (prop_seg_o == '0 && phase1_o == '0 && phase2_o == '0 &&
                           rjw_o == '0 && tol_o == '0 && tol_rjw_o == '0 && tol_phase_o == '0));
endmodule

bind can_seg_solver can_seg_solver_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .prop_seg_o  (prop_seg_o),
  .phase1_o    (phase1_o),
  .phase2_o    (phase2_o),
  .rjw_o       (rjw_o),
  .tol_rjw_o   (tol_rjw_o),
  .tol_phase_o (tol_phase_o),
  .tol_o       (tol_o)
);

// File: tb/test_can_seg_solver.sv
`timescale 1ns/1ps
module test_can_seg_solver;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] rtt_ns_i = '0;
  logic [15:0] tq_ns_i = '0;
  logic [4:0]  nbt_i = '0;
  logic        done_o, err_o;
  logic [3:0]  prop_seg_o;
  logic [4:0]  phase1_o, phase2_o;
  logic [2:0]  rjw_o;
  logic [15:0] tol_rjw_o, tol_phase_o, tol_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  can_seg_solver i_can_seg_solver (
    .clk_i, .rst_ni, .start_i, .rtt_ns_i, .tq_ns_i, .nbt_i,
    .done_o, .err_o, .prop_seg_o, .phase1_o, .phase2_o, .rjw_o,
    .tol_rjw_o, .tol_phase_o, .tol_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected results from the requirements.
  task automatic model(input int rtt, input int tq, input int nbt,
                       output int e, output int pr, output int p1, output int p2,
                       output int rj, output int t1, output int t2, output int t);
    int rem, mn;
    e = 0; pr = 0; p1 = 0; p2 = 0; rj = 0; t1 = 0; t2 = 0; t = 0;
    if (nbt < 8 || nbt > 25 || tq == 0) begin e = 1; return; end
    pr = (rtt + tq - 1) / tq;
    if (pr > 8) begin e = 1; pr = 0; return; end
    rem = nbt - 1 - pr;
    if (rem < 2) begin e = 1; pr = 0; return; end
    p1 = rem / 2;
    p2 = rem - p1;
    rj = (p1 < 4) ? p1 : 4;
    t1 = (rj * 65536) / (20 * nbt);
    mn = (p1 < p2) ? p1 : p2;
    t2 = (mn * 65536) / (2 * (13 * nbt - p2));
    t = (t1 < t2) ? t1 : t2;
  endtask

  task automatic kick(input int rtt, input int tq, input int nbt);
    @(negedge clk_i);
    rtt_ns_i = 16'(rtt); tq_ns_i = 16'(tq); nbt_i = 5'(nbt);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (done_o !== 1'b1 && n < 400) begin
      @(negedge clk_i);
      n++;
    end
    chk({tag, " done seen"}, int'(done_o === 1'b1), 1);
  endtask

  task automatic compare(input string tag, input string ptag, input int rtt, input int tq, input int nbt);
    int e, pr, p1, p2, rj, t1, t2, t;
    model(rtt, tq, nbt, e, pr, p1, p2, rj, t1, t2, t);
    chk({tag, " err"}, int'(err_o), e);
    chk({tag, " R1 prop"}, int'(prop_seg_o), pr);
    chk({tag, " ", ptag, " ph1"}, int'(phase1_o), p1);
    chk({tag, " ", ptag, " ph2"}, int'(phase2_o), p2);
    chk({tag, " R4 rjw"}, int'(rjw_o), rj);
    chk({tag, " R5 tol_rjw"}, int'(tol_rjw_o), t1);
    chk({tag, " R6 tol_phase"}, int'(tol_phase_o), t2);
    chk({tag, " R7 tol"}, int'(tol_o), t);
  endtask

  task automatic run(input string tag, input string ptag, input int rtt, input int tq, input int nbt);
    kick(rtt, tq, nbt);
    wait_done(tag);
    compare(tag, ptag, rtt, tq, nbt);
    @(negedge clk_i);
    chk({tag, " R11 done one cycle"}, int'(done_o), 0);
  endtask

  task automatic t_reset;
    chk("R11 reset done", int'(done_o), 0);
    chk("R8 reset err", int'(err_o), 0);
    chk("R7 reset tol", int'(tol_o), 0);
    chk("R1 reset prop", int'(prop_seg_o), 0);
  endtask

  task automatic t_even_roundup;
    run("R2 even", "R2", 800, 125, 16);
    chk("R1 prop 800/125", int'(prop_seg_o), 7);
    chk("R7 tol literal", int'(tol_o), 642);
  endtask

  task automatic t_exact_multiple;
    run("R1 exact", "R2", 700, 100, 16);
    chk("R1 exact prop", int'(prop_seg_o), 7);
  endtask

  task automatic t_odd;
    run("R3 odd", "R3", 250, 100, 11);
    chk("R3 ph1", int'(phase1_o), 3);
    chk("R3 ph2", int'(phase2_o), 4);
  endtask

  task automatic t_rjw_cap;
    run("R4 cap", "R3", 100, 100, 25);
    chk("R4 capped", int'(rjw_o), 4);
    chk("R7 picks rjw bound", int'(tol_o), int'(tol_rjw_o));
  endtask

  task automatic t_short_bit;
    run("R10 rem2", "R2", 500, 100, 8);
    run("R2 nbt10", "R2", 100, 100, 10);
  endtask

  task automatic t_errors;
    run("R8 nbt7", "R8", 100, 100, 7);
    chk("R8 nbt7 flag", int'(err_o), 1);
    run("R8 nbt26", "R8", 100, 100, 26);
    chk("R8 nbt26 flag", int'(err_o), 1);
    run("R8 tq0", "R8", 100, 0, 16);
    chk("R8 tq0 flag", int'(err_o), 1);
    run("R9 prop8 ok", "R3", 800, 100, 16);
    chk("R9 prop8 flag", int'(err_o), 0);
    run("R9 prop9", "R9", 801, 100, 20);
    chk("R9 prop9 flag", int'(err_o), 1);
    run("R10 rem1", "R10", 600, 100, 8);
    chk("R10 rem1 flag", int'(err_o), 1);
    run("R8 recover", "R2", 800, 125, 16);
  endtask

  task automatic t_ignore_start;
    int extra = 0;
    kick(800, 125, 16);
    repeat (10) @(negedge clk_i);
    rtt_ns_i = 16'd100; tq_ns_i = 16'd100; nbt_i = 5'd25; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done("R12 busy start");
    compare("R12 busy start", "R2", 800, 125, 16);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk_i);
      if (done_o) extra++;
    end
    chk("R12 no extra done", extra, 0);
  endtask

  task automatic t_hold;
    run("R11 hold base", "R3", 250, 100, 11);
    rtt_ns_i = 16'd900; tq_ns_i = 16'd0; nbt_i = 5'd3;
    repeat (20) @(negedge clk_i);
    compare("R11 held", "R3", 250, 100, 11);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_even_roundup();
    t_exact_multiple();
    t_odd();
    t_rjw_cap();
    t_short_bit();
    t_errors();
    t_ignore_start();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule